// File: doc/BRIEF.md
# Shared-Bus Collision-Resolving Serial Transmitter

This block sends one prepared NRZ frame onto a serial line that several stations share through an open-drain wired-AND connection. It reads the frame byte by byte from a buffer that the host keeps filled, and it shifts the frame out one bit per clock. The host gives only a request, a byte count and a priority value. A second input senses the real level of the shared line.

The line is logic 1 at rest. The transmitter starts only after it has seen a run of consecutive ones on the line, and the priority value sets how long that run must be. While it sends, it compares every bit it drives with the level it senses. If a bit differs, another station has won the line. The transmitter then releases the line at once and tries again later from the first bit. A clear-to-send input also gates the transmitter. If that permission is withdrawn in the middle of a frame, the frame is cut off and then sent again without any host action.

When the frame completes, a done pulse tells the host that it may reuse the buffer. If collisions keep happening past a set limit, an error pulse gives the frame up.

Top module: `bcr_tx`

## Requirements
- R1: While reset is asserted, `txd` is 1 and every event output is 0. Outside a frame bit, `txd` is 1 in every cycle, including the cycles that wait for the line, the cycles with `cts` low and the cycles after a frame has ended.
- R2: The edge that accepts `tx_req` does not count toward the idle run. At each later edge, `cxd`=1 adds one to the run and `cxd`=0 sets the run back to zero. The first data bit appears on `txd` right after the edge that samples the run's (8+`prio`)-th consecutive one.
- R3: The frame is 8×`frm_len` bits long, where `frm_len` is at least 1. Bytes go out in index order starting at 0, and each byte goes out least significant bit first, one bit per clock. `byte_idx` gives the index of the byte that holds the next bit to send, and `byte_data` must return that byte in the same cycle.
- R4: A collision is an edge during a frame at which `txd` differs from `cxd`. After that edge, `txd` is 1 and `coll_o` pulses for one cycle. The frame then starts again from bit 0 once a new idle run as in R2 has been seen, counted from the edges after the collision.
- R5: At most `MAX_RETRY` (default 3) automatic retries follow collisions. The next collision raises `err_o` in the same cycle as `coll_o`, and the block returns to idle with no `done_o`.
- R6: If `cts` is 0 at an edge during a frame, `abort_o` pulses for one cycle after that edge and `txd` goes to 1. Once `cts` is high again and the idle run as in R2 is met, the whole frame is sent again from bit 0.
- R7: While `cts` is 0, no frame starts. The idle run keeps counting during that time, so if the run is already met, the first bit appears right after the first edge that samples `cts` high.
- R8: At the edge after the last bit, `done_o` pulses for one cycle and `txd` returns to 1. The block then accepts a new request.
- R9: `done_o`, `coll_o` and `abort_o` are never high in the same cycle, and `err_o` is only high together with `coll_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit is sent per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Request to send the frame in the buffer, sampled while idle |
| frm_len | input | LEN_W | Frame length in bytes, at least 1 |
| prio | input | PRIO_W | Priority; the idle run needed before sending is 8+prio |
| byte_idx | output | LEN_W | Index of the buffer byte that holds the next bit |
| byte_data | input | 8 | Buffer byte at `byte_idx` |
| cts | input | 1 | Clear-to-send permission, active high |
| cxd | input | 1 | Sensed level of the shared line |
| txd | output | 1 | Data driven onto the line; 1 releases it |
| done_o | output | 1 | Frame sent; the buffer may be reused |
| coll_o | output | 1 | A collision was detected |
| abort_o | output | 1 | The frame was cut off because permission was withdrawn |
| err_o | output | 1 | The retry limit was exceeded and the frame was dropped |

## Verification
The bench aims at the off-by-one edges of the idle run. A design that counted the accepting edge, or that did not restart the run when the line went low, would start a cycle early or start while another station still held the line. It forces collisions partway into a frame and checks that the frame restarts from bit 0. A design that resumed from the colliding bit would send a corrupt frame. It uses up the retry limit to check that the error appears on exactly the fourth collision and that nothing is sent afterwards. It withdraws permission mid-frame and also before the start. A design that kept sending, or that lost the idle run while it waited, would show wrong bits or a late start.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } bcr_state_e;
endpackage

// File: rtl/bcr_idle_run.sv
// Counts consecutive sensed ones on the shared line, saturating at the need.
module bcr_idle_run #(
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cxd,
  input  logic [RUN_W-1:0] need,
  output logic             ready
);
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    if (clr || !cxd)      run_d = '0;
    else if (run_q >= need) run_d = run_q;
    else                  run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // The edge that samples this one completes the run.
  assign ready = cxd && !clr && (run_q >= need - 1'b1);
endmodule

// File: rtl/bcr_retry_ctr.sv
// Counts collision retries of the current frame.
module bcr_retry_ctr #(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int CNT_W = $clog2(MAX_RETRY + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign spent = (cnt_q == CNT_W'(MAX_RETRY));
endmodule

// File: rtl/bcr_tx.sv
module bcr_tx
  import bcr_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int PRIO_W    = 3,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [PRIO_W-1:0] prio,
  output logic [LEN_W-1:0]  byte_idx,
  input  logic [7:0]        byte_data,
  input  logic              cts,
  input  logic              cxd,
  output logic              txd,
  output logic              done_o,
  output logic              coll_o,
  output logic              abort_o,
  output logic              err_o
);
  localparam int BP_W  = LEN_W + 3;
  localparam int RUN_W = $clog2(8 + (1 << PRIO_W)) + 1;

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bcr_state_e        st_q, st_d;
  logic [BP_W-1:0]   fptr_q, fptr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              txd_q, txd_d;
  logic              done_q, done_d, coll_q, coll_d;
  logic              abort_q, abort_d, err_q, err_d;
  logic              run_clr, run_ready, ret_clr, ret_inc, ret_spent;
  logic [RUN_W-1:0]  need;
  logic [BP_W-1:0]   total_bits;
  logic              cur_bit;
  logic              sending;

  assign need       = RUN_W'(8) + RUN_W'(prio_q);
  assign total_bits = {len_q, 3'b000};
  assign byte_idx   = fptr_q[BP_W-1:3];
  assign cur_bit    = byte_data[fptr_q[2:0]];
  assign sending    = (st_q == ST_SEND);

  bcr_idle_run #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_i_n), .clr(run_clr), .cxd(cxd),
    .need(need), .ready(run_ready)
  );

  bcr_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_i_n), .clr(ret_clr), .inc(ret_inc),
    .spent(ret_spent)
  );

  always_comb begin
    st_d    = st_q;
    fptr_d  = fptr_q;
    len_d   = len_q;
    prio_d  = prio_q;
    txd_d   = 1'b1;
    done_d  = 1'b0;
    coll_d  = 1'b0;
    abort_d = 1'b0;
    err_d   = 1'b0;
    run_clr = 1'b0;
    ret_clr = 1'b0;
    ret_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_req) begin
          st_d    = ST_WAIT;
          len_d   = frm_len;
          prio_d  = prio;
          fptr_d  = '0;
          run_clr = 1'b1;
          ret_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cts && run_ready) begin
          st_d   = ST_SEND;
          txd_d  = cur_bit;
          fptr_d = fptr_q + 1'b1;
        end
      end
      ST_SEND: begin
        if (!cts) begin
          abort_d = 1'b1;
          st_d    = ST_WAIT;
          fptr_d  = '0;
          run_clr = 1'b1;
        end else if (txd_q != cxd) begin
          coll_d = 1'b1;
          fptr_d = '0;
          if (ret_spent) begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            ret_inc = 1'b1;
            run_clr = 1'b1;
            st_d    = ST_WAIT;
          end
        end else if (fptr_q == total_bits) begin
          done_d = 1'b1;
          fptr_d = '0;
          st_d   = ST_IDLE;
        end else begin
          txd_d  = cur_bit;
          fptr_d = fptr_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      fptr_q  <= '0;
      len_q   <= '0;
      prio_q  <= '0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      fptr_q  <= fptr_d;
      len_q   <= len_d;
      prio_q  <= prio_d;
      txd_q   <= txd_d;
      done_q  <= done_d;
      coll_q  <= coll_d;
      abort_q <= abort_d;
      err_q   <= err_d;
    end
  end

  assign txd     = txd_q;
  assign done_o  = done_q;
  assign coll_o  = coll_q;
  assign abort_o = abort_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bcr_tx_chk.sv
module bcr_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cts,
  input logic cxd,
  input logic txd,
  input logic sending,
  input logic done_o,
  input logic coll_o,
  input logic abort_o,
  input logic err_o
);
  // R1 / R7: without permission the line is released at the next cycle.
  a_r1_no_cts_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !cts |=> txd);

  // R4: a sensed mismatch while sending with permission is a collision.
  a_r4_mismatch_collides: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && cts && (txd != cxd)) |=> (coll_o && txd));

  // R6: loss of permission while sending aborts the frame.
  a_r6_cts_loss_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !cts) |=> (abort_o && txd));

  // R8: the line is released when a frame completes.
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> txd);

  // R9: events are exclusive, and the error only comes with a collision.
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, coll_o, abort_o}));

  a_r9_err_with_coll: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> coll_o);
endmodule

bind bcr_tx bcr_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cts(cts), .cxd(cxd), .txd(txd),
  .sending(sending), .done_o(done_o), .coll_o(coll_o),
  .abort_o(abort_o), .err_o(err_o)
);

// File: tb/bcr_tx_tb.sv
`timescale 1ns/1ps
module bcr_tx_tb;
  localparam int LEN_W = 6;
  localparam int PRIO_W = 3;

  logic clk = 1'b0;
  logic rst_n, tx_req, cts, jam;
  logic [LEN_W-1:0] frm_len, byte_idx;
  logic [PRIO_W-1:0] prio;
  logic [7:0] mem [0:63];
  logic [7:0] byte_data;
  logic cxd, txd, done_o, coll_o, abort_o, err_o;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign byte_data = mem[byte_idx];
  assign cxd = txd & ~jam;   // wired-AND line; jam models another station

  bcr_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .frm_len(frm_len),
    .prio(prio), .byte_idx(byte_idx), .byte_data(byte_data), .cts(cts),
    .cxd(cxd), .txd(txd), .done_o(done_o), .coll_o(coll_o),
    .abort_o(abort_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_req(input int nbytes, input int pr);
    @(negedge clk);
    frm_len = LEN_W'(nbytes);
    prio = PRIO_W'(pr);
    tx_req = 1'b1;
    @(posedge clk);
    #1 tx_req = 1'b0;
  endtask

  // R1/R2: line stays released and quiet for n cycles.
  task automatic wait_ones(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R1 idle ones", txd, 1);
      chk("R2 no early event", {done_o, coll_o, abort_o, err_o}, 0);
    end
  endtask

  // R3: bits in byte order, LSB first.
  task automatic check_bits(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      @(negedge clk);
      chk("R3 bit order", txd, int'(mem[i / 8][i % 8]));
      chk("R3 no event mid frame", {done_o, coll_o, abort_o}, 0);
    end
  endtask

  task automatic check_done();
    @(negedge clk);
    chk("R8 done pulse", done_o, 1);
    chk("R8 line released", txd, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_req = 1'b0; cts = 1'b1; jam = 1'b0;
    frm_len = '0; prio = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset events", {done_o, coll_o, abort_o, err_o}, 0);
    rst_n = 1'b1;
    wait_ones(4);
  endtask

  task automatic t_plain();
    mem[0] = 8'h5A; mem[1] = 8'hC3;
    start_req(2, 0);
    wait_ones(8);
    check_bits(0, 16);
    check_done();
    wait_ones(3);
  endtask

  task automatic t_priority();
    mem[0] = 8'h96;
    start_req(1, 5);
    wait_ones(13);           // R2: 8 + 5 ones
    check_bits(0, 8);
    check_done();
  endtask

  task automatic t_busy_line();
    mem[0] = 8'h3B;
    jam = 1'b1;
    start_req(1, 0);
    wait_ones(10);           // R2: run cannot build while line is held low
    jam = 1'b0;
    wait_ones(7);
    check_bits(0, 8);
    check_done();
  endtask

  task automatic t_collision();
    mem[0] = 8'hA5;
    start_req(1, 0);
    wait_ones(8);
    check_bits(0, 3);        // bit 2 is a one
    jam = 1'b1;
    @(negedge clk);
    chk("R4 collision pulse", coll_o, 1);
    chk("R4 line released", txd, 1);
    chk("R5 no error on first", err_o, 0);
    jam = 1'b0;
    wait_ones(7);
    check_bits(0, 8);        // R4 restart from bit 0
    check_done();
  endtask

  task automatic t_retry_limit();
    mem[0] = 8'hFF;
    start_req(1, 0);
    wait_ones(8);
    for (int a = 0; a < 4; a++) begin
      check_bits(0, 1);
      jam = 1'b1;
      @(negedge clk);
      chk("R5 collision", coll_o, 1);
      chk("R5 error on limit", err_o, (a == 3) ? 1 : 0);
      chk("R5 no done", done_o, 0);
      jam = 1'b0;
      if (a < 3) wait_ones(7);
    end
    wait_ones(20);           // R5 gave up: nothing more sent
  endtask

  task automatic t_cts_loss();
    mem[0] = 8'h3C; mem[1] = 8'h81;
    start_req(2, 1);
    wait_ones(9);
    check_bits(0, 5);
    cts = 1'b0;
    @(negedge clk);
    chk("R6 abort pulse", abort_o, 1);
    chk("R6 line released", txd, 1);
    wait_ones(10);
    cts = 1'b1;
    check_bits(0, 16);       // R6 whole frame again
    check_done();
  endtask

  task automatic t_cts_low_start();
    mem[0] = 8'h6D;
    cts = 1'b0;
    start_req(1, 0);
    wait_ones(20);           // R7 no start without permission
    cts = 1'b1;
    check_bits(0, 8);        // R7 run already met: starts at once
    check_done();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_priority();
    t_busy_line();
    t_collision();
    t_retry_limit();
    t_cts_loss();
    t_cts_low_start();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule